// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel together with the 16-bit timer counter it watches. On each timer tick that the block is running, the counter advances according to one of four counting modes and is compared against a 16-bit compare register. An unblocked equality raises a match flag and drives a waveform pin through a 2-bit pin action: none, toggle, clear or set. The pin can also be driven by software through a force strobe, and in the variable-TOP PWM mode the pin takes the opposite action when the counter passes bottom.

Software reaches the counter and compare register one byte at a time. A write to either high byte lands in a single temporary byte shared by both registers. A write to a low byte loads the whole 16-bit register in one cycle, taking its upper half from that temporary byte. Any software write to the counter suppresses the compare match on the next timer tick, even while the counter is stopped, so the counter can be preset to the compare value without a spurious event.

Top module: `occ_channel`

## Requirements
- R1: A write to address 1 (counter high) or address 3 (compare high) updates only the shared temporary byte; neither the counter nor the compare register changes.
- R2: A write of byte D to address 0 (counter low) or address 2 (compare low) loads that register with {temporary byte, D} on the same clock edge.
- R3: A timer tick is `tick` high while the run bit (control bit 4) is set. Control bits [3:2] choose the count mode: 00 counts up and wraps, 01 reloads 0 on a match and otherwise counts up, 11 counts up to 0xFFFF, then down to 0, and then back up. Without a timer tick and without a counter write, the counter holds.
- R4: A match happens on a timer tick when the counter equals the compare register and matching is not blocked. A match sets the flag (address 5 bit 0, also the `match_flag` port) on the next edge. Writing 1 to address 5 bit 0 clears the flag, and a match in the same cycle wins over the clear.
- R5: Control bits [1:0] select the pin action on a match: 00 none, 01 toggle, 10 clear, 11 set. A change to these bits is used by the very next match.
- R6: A write to address 0 blocks any match in its own cycle and on the next timer tick, even if the counter was stopped when it was written. Writing the counter equal to the compare value therefore loses that match.
- R7: Writing control bit 7 as 1 in count mode 00 or 01 applies the pin action given in the same write, without setting the flag and without changing the counter. Bit 7 reads back as 0. In count modes 10 and 11 the strobe has no effect.
- R8: The pin keeps its value when the count mode changes.
- R9: In count mode 10 the compare value is TOP: a match reloads 0. A blocked TOP match lets the counter run on to 0xFFFF and wrap to 0. On a tick with the counter at 0, action 10 sets the pin and action 11 clears it, and a match on that same tick takes priority.
- R10: After reset the counter, compare register, control bits, flag and pin are all 0.
- R11: `rd_data` shows, one cycle after `rd_addr` is applied, the selected byte: 0/1 counter low/high, 2/3 compare low/high, 4 control {0,0,0,run,mode[1:0],action[1:0]}, 5 status {0…0,flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| wave_out | output | 1 | Waveform pin register |
| match_flag | output | 1 | Compare match flag |

## Verification
Most internal faults show up on the pin or the flag at the first timer tick that should match, so the bench places the counter one or two ticks below the compare value before each check. A block latch that fails to set or never clears is only visible on the tick right after a counter write, so that tick is checked directly. A bad reload or wrong direction logic appears as a wrong counter byte on the read port after one or two ticks. A temporary-byte fault appears on the read after the next low-byte write.

// File: rtl/occ_pkg.sv
package occ_pkg;

  localparam int ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

  // count modes
  localparam logic [1:0] CM_UP     = 2'b00;
  localparam logic [1:0] CM_RELOAD = 2'b01;
  localparam logic [1:0] CM_PWMTOP = 2'b10;
  localparam logic [1:0] CM_UPDOWN = 2'b11;

  // pin actions
  localparam logic [1:0] PA_NONE   = 2'b00;
  localparam logic [1:0] PA_TOGGLE = 2'b01;
  localparam logic [1:0] PA_CLEAR  = 2'b10;
  localparam logic [1:0] PA_SET    = 2'b11;

  function automatic logic pin_after(logic [1:0] act, logic cur);
    logic r;
    case (act)
      PA_TOGGLE: r = ~cur;
      PA_CLEAR:  r = 1'b0;
      PA_SET:    r = 1'b1;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/occ_regif.sv
module occ_regif
  import occ_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              flag_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [1:0]        act_q,
  output logic [1:0]        mode_q,
  output logic              run_q,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wr_val,
  output logic              force_p,
  output logic [1:0]        force_act,
  output logic              flag_clr
);

  logic [BYTE_W-1:0] tmp_q;
  logic [BYTE_W-1:0] rd_mux;
  logic              ctrl_wr;

  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
  assign cnt_wr     = wr_en && (wr_addr == A_CNT_LO);
  assign cnt_wr_val = {tmp_q, wr_data};
  // strobe only honoured when the written mode is a non-PWM one
  assign force_p    = ctrl_wr && wr_data[7] && !wr_data[3];
  assign force_act  = wr_data[1:0];
  assign flag_clr   = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CNT_LO: rd_mux = cnt_q[BYTE_W-1:0];
      A_CNT_HI: rd_mux = cnt_q[CNT_W-1:BYTE_W];
      A_CMP_LO: rd_mux = cmp_q[BYTE_W-1:0];
      A_CMP_HI: rd_mux = cmp_q[CNT_W-1:BYTE_W];
      A_CTRL:   rd_mux = {{(BYTE_W-5){1'b0}}, run_q, mode_q, act_q};
      A_STAT:   rd_mux = {{(BYTE_W-1){1'b0}}, flag_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q   <= '0;
      cmp_q   <= '0;
      act_q   <= PA_NONE;
      mode_q  <= CM_UP;
      run_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_mux;
      if (wr_en) begin
        case (wr_addr)
          A_CNT_HI, A_CMP_HI: tmp_q <= wr_data;
          A_CMP_LO:           cmp_q <= {tmp_q, wr_data};
          A_CTRL: begin
            act_q  <= wr_data[1:0];
            mode_q <= wr_data[3:2];
            run_q  <= wr_data[4];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/occ_counter.sv
module occ_counter
  import occ_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match,
  output logic             bottom
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic             blk_q;
  logic             up_q;
  logic             tmr;
  logic [CNT_W-1:0] cnt_nx;
  logic             up_nx;

  assign tmr    = tick && run;
  assign match  = tmr && !blk_q && !cnt_wr && (cnt_q == cmp);
  assign bottom = tmr && !cnt_wr && (mode == CM_PWMTOP) && (cnt_q == CNT_ZERO);

  always_comb begin
    cnt_nx = cnt_q + CNT_ONE;
    up_nx  = 1'b1;
    case (mode)
      CM_RELOAD, CM_PWMTOP: cnt_nx = match ? CNT_ZERO : cnt_q + CNT_ONE;
      CM_UPDOWN: begin
        up_nx = up_q;
        if (up_q) begin
          if (cnt_q == CNT_MAX) begin
            up_nx  = 1'b0;
            cnt_nx = CNT_MAX - CNT_ONE;
          end else begin
            cnt_nx = cnt_q + CNT_ONE;
          end
        end else begin
          if (cnt_q == CNT_ZERO) begin
            up_nx  = 1'b1;
            cnt_nx = CNT_ONE;
          end else begin
            cnt_nx = cnt_q - CNT_ONE;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
      up_q  <= 1'b1;
    end else begin
      if (cnt_wr) begin
        cnt_q <= cnt_wr_val;
        blk_q <= 1'b1;
      end else if (tmr) begin
        cnt_q <= cnt_nx;
        blk_q <= 1'b0;
      end
      if (mode != CM_UPDOWN)
        up_q <= 1'b1;
      else if (tmr && !cnt_wr)
        up_q <= up_nx;
    end
  end

endmodule

// File: rtl/occ_wave.sv
module occ_wave
  import occ_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match,
  input  logic       bottom,
  input  logic [1:0] act,
  input  logic       force_p,
  input  logic [1:0] force_act,
  input  logic       flag_clr,
  output logic       pin_q,
  output logic       flag_q
);

  logic pin_nx;

  always_comb begin
    pin_nx = pin_q;
    if (match)
      pin_nx = pin_after(act, pin_q);
    else if (bottom) begin
      if (act == PA_CLEAR)
        pin_nx = 1'b1;
      else if (act == PA_SET)
        pin_nx = 1'b0;
    end else if (force_p)
      pin_nx = pin_after(force_act, pin_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_nx;
      if (match)
        flag_q <= 1'b1;
      else if (flag_clr)
        flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/occ_channel.sv
module occ_channel
  import occ_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              wave_out,
  output logic              match_flag
);

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] cnt_wr_val;
  logic [1:0]       act_w;
  logic [1:0]       mode_w;
  logic [1:0]       force_act;
  logic             run_w;
  logic             cnt_wr;
  logic             force_p;
  logic             flag_clr;
  logic             match_w;
  logic             bottom_w;

  occ_regif #(.BYTE_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .cnt_q      (cnt_w),
    .flag_q     (match_flag),
    .rd_data    (rd_data),
    .cmp_q      (cmp_w),
    .act_q      (act_w),
    .mode_q     (mode_w),
    .run_q      (run_w),
    .cnt_wr     (cnt_wr),
    .cnt_wr_val (cnt_wr_val),
    .force_p    (force_p),
    .force_act  (force_act),
    .flag_clr   (flag_clr)
  );

  occ_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run_w),
    .mode       (mode_w),
    .cmp        (cmp_w),
    .cnt_wr     (cnt_wr),
    .cnt_wr_val (cnt_wr_val),
    .cnt_q      (cnt_w),
    .match      (match_w),
    .bottom     (bottom_w)
  );

  occ_wave u_wave (
    .clk       (clk),
    .rst       (rst),
    .match     (match_w),
    .bottom    (bottom_w),
    .act       (act_w),
    .force_p   (force_p),
    .force_act (force_act),
    .flag_clr  (flag_clr),
    .pin_q     (wave_out),
    .flag_q    (match_flag)
  );

endmodule

// File: rtl/occ_channel_chk.sv
module occ_channel_chk
  import occ_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
)(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              wave_out,
  input logic              match_flag,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  cmp_w,
  input logic              match_w,
  input logic              bottom_w
);

  assert_hi_to_temp_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CMP_HI) |=> $stable(cmp_w));

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && wr_addr == A_CNT_LO)) |=> $stable(cnt_w));

  assert_flag_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    match_w |=> match_flag);

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STAT && wr_data[0] && !match_w) |=> !match_flag);

  assert_pin_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!match_w && !bottom_w && !(wr_en && wr_addr == A_CTRL)) |=> $stable(wave_out));

  assert_cnt_write_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CNT_LO) |=> !match_w);

  assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL && wr_data[7] && !match_w) |=> $stable(match_flag));

  assert_force_pwm_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL && wr_data[7] && wr_data[3] && !match_w && !bottom_w)
      |=> $stable(wave_out));

  assert_ctrl_rd_top_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTRL) |=> (rd_data[BYTE_W-1] == 1'b0));

endmodule

bind occ_channel occ_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .wave_out   (wave_out),
  .match_flag (match_flag),
  .cnt_w      (cnt_w),
  .cmp_w      (cmp_w),
  .match_w    (match_w),
  .bottom_w   (bottom_w)
);

// File: tb/tb_occ_channel.sv
module tb_occ_channel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wave_out;
  logic       match_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  occ_channel dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wave_out(wave_out), .match_flag(match_flag)
  );

  localparam logic [1:0] K_WR = 2'd0, K_TICK = 2'd1, K_RD = 2'd2, K_PIN = 2'd3;
  typedef struct packed { logic [1:0] kind; logic [2:0] addr; logic [7:0] data; } vec_t;
  localparam int NV = 17;
  // normal mode, toggle action, compare 5, counter preset 3
  localparam vec_t VEC [NV] = '{
    '{K_WR,  3'd3, 8'h00}, '{K_WR,  3'd2, 8'h05}, '{K_WR,  3'd1, 8'h00},
    '{K_WR,  3'd0, 8'h03}, '{K_WR,  3'd4, 8'h11}, '{K_RD,  3'd4, 8'h11},
    '{K_TICK,3'd0, 8'h00}, '{K_TICK,3'd0, 8'h00}, '{K_PIN, 3'd0, 8'h00},
    '{K_RD,  3'd5, 8'h00}, '{K_TICK,3'd0, 8'h00}, '{K_PIN, 3'd0, 8'h01},
    '{K_RD,  3'd5, 8'h01}, '{K_RD,  3'd0, 8'h06}, '{K_WR,  3'd5, 8'h01},
    '{K_RD,  3'd5, 8'h00}, '{K_RD,  3'd2, 8'h05}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic pin(input string tag, input logic exp);
    @(negedge clk); chk(tag, {7'd0, wave_out}, {7'd0, exp});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    pin("R10 pin", 1'b0);
    rd("R10 cnt lo", 3'd0, 8'h00);
    rd("R10 cmp hi", 3'd3, 8'h00);
    rd("R10 ctrl", 3'd4, 8'h00);
    rd("R10 flag", 3'd5, 8'h00);

    // table: R2 loads, R3 counting, R4 flag, R5 toggle, R11 readback
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR:   wr(VEC[i].addr, VEC[i].data);
        K_TICK: tk();
        K_RD:   rd($sformatf("R2/R4/R11 table %0d", i), VEC[i].addr, VEC[i].data);
        default: pin($sformatf("R4/R5 table %0d", i), VEC[i].data[0]);
      endcase
    end

    // R6: counter written equal to compare while stopped loses the match
    wr(3'd4, 8'h01); wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd4, 8'h11);
    tk();
    pin("R6 pin kept", 1'b1);
    rd("R6 no flag", 3'd5, 8'h00);
    rd("R6 counter moved", 3'd0, 8'h06);

    // R7: force in normal mode clears pin, no flag, counter untouched
    wr(3'd4, 8'h82);
    pin("R7 force clear", 1'b0);
    rd("R7 no flag", 3'd5, 8'h00);
    rd("R7 counter held", 3'd0, 8'h06);
    rd("R7 strobe reads 0", 3'd4, 8'h02);

    // R5: action change takes effect on the next match
    wr(3'd4, 8'h83);
    pin("R7 force set", 1'b1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h04); wr(3'd4, 8'h13);
    tk();
    wr(3'd4, 8'h12);
    tk();
    pin("R5 new action used", 1'b0);
    rd("R4 flag set", 3'd5, 8'h01);
    wr(3'd5, 8'h01);

    // R7 and R8: force ignored in PWM mode, pin kept over mode change
    wr(3'd4, 8'h83);
    wr(3'd4, 8'h89);
    pin("R7 R8 pin kept", 1'b1);
    rd("R11 ctrl", 3'd4, 8'h09);

    // R3: reload-on-match mode
    wr(3'd4, 8'h05); wr(3'd1, 8'h00); wr(3'd0, 8'h04); wr(3'd4, 8'h15);
    tk(); tk();
    rd("R3 reload to 0", 3'd0, 8'h00);
    pin("R3 toggle at match", 1'b0);
    rd("R4 flag reload", 3'd5, 8'h01);
    wr(3'd5, 8'h01);

    // R9: blocked TOP match runs on to 0xFFFF and wraps
    wr(3'd4, 8'h08); wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd4, 8'h18);
    tk();
    rd("R9 passed TOP", 3'd0, 8'h06);
    rd("R9 no flag", 3'd5, 8'h00);
    wr(3'd1, 8'hFF); wr(3'd0, 8'hFF);
    tk();
    rd("R9 wrap hi", 3'd1, 8'h00);
    rd("R9 wrap lo", 3'd0, 8'h00);
    wr(3'd4, 8'h1A);
    tk();
    pin("R9 set at bottom", 1'b1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h04);
    tk(); tk();
    pin("R9 clear at TOP", 1'b0);
    rd("R9 reload", 3'd0, 8'h00);
    rd("R9 flag", 3'd5, 8'h01);
    wr(3'd5, 8'h01);

    // R3: up/down turns at 0xFFFF
    wr(3'd4, 8'h0C); wr(3'd1, 8'hFF); wr(3'd0, 8'hFE); wr(3'd4, 8'h1C);
    tk(); tk(); tk();
    rd("R3 updown lo", 3'd0, 8'hFD);
    rd("R3 updown hi", 3'd1, 8'hFF);

    // R1 R2: shared temporary byte
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h12);
    rd("R1 cmp hi unchanged", 3'd3, 8'h00);
    rd("R1 cmp lo unchanged", 3'd2, 8'h05);
    wr(3'd2, 8'h34);
    rd("R2 cmp hi", 3'd3, 8'h12);
    rd("R2 cmp lo", 3'd2, 8'h34);
    wr(3'd1, 8'hAB);
    rd("R1 cnt hi unchanged", 3'd1, 8'hFF);
    wr(3'd2, 8'h01);
    rd("R2 shared temp", 3'd3, 8'hAB);

    finish_run();
  end

endmodule